// File: doc/BRIEF.md
# Integer Add/Subtract and Compare Unit

This unit is the integer arithmetic stage of a small load/store datapath. It takes a first operand, a second operand that is either a register value or a short immediate widened by sign extension, and a three-bit operation code. It produces a result word for four kinds of operation: addition, subtraction, and signed and unsigned less-than comparison. Addition and subtraction each come in a trapping form and a non-trapping form.

Subtraction adds the inverted second operand with a carry-in of one. Only the trapping forms can raise the overflow request, which the surrounding pipeline turns into an exception. The non-trapping forms wrap silently. They still sign-extend the immediate, because the immediate always sign-extends, whatever the operation. The signed comparison takes the sign of the true difference, so it stays correct when the subtraction itself overflows.

Result and overflow request are registered: they show the operation sampled at the previous rising clock edge. All widths are parameters, and the default is a 32-bit word with a 16-bit immediate.

Top module: `int_addsub_unit`

## Requirements
- R1: While synchronous reset is high, the result and overflow request are zero on the clock edge that follows.
- R2: Code 000 (signed add) gives the low W bits of A+B2. The overflow request is high exactly when A and B2 have the same sign and the sum's sign differs from it. Operands of opposite sign never overflow, and the wrapped sum still appears on the result.
- R3: Code 001 (signed subtract) gives the low W bits of A-B2, computed as A + ~B2 + 1. The overflow request is high exactly when the true difference lies outside -2^(W-1) to 2^(W-1)-1, so B2 = 0 never overflows while A = 0, B2 = -2^(W-1) does.
- R4: Codes 010 (unsigned add) and 011 (unsigned subtract) give the low W bits of A+B2 and A-B2, and never raise the overflow request.
- R5: Code 100 (signed less-than) gives 1 in bit 0 and zeros above when A < B2 as two's complement values, also when A-B2 overflows. Otherwise the result is 0. It never raises overflow.
- R6: Code 101 (unsigned less-than) gives 1 when A < B2 as unsigned values, so a pattern with the top bit set counts as large. Otherwise the result is 0. It never raises overflow.
- R7: With imm_sel = 1, B2 is the immediate with its top bit (bit IMM_W-1) copied into all upper bits, for every operation including unsigned add. With imm_sel = 0, B2 is opnd_b.
- R8: Codes 110 and 111 give a zero result and no overflow.
- R9: Outputs change only at a rising clock edge and show the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Operation select, encodings in R2 to R8 |
| imm_sel | input | 1 | 1 selects the sign-extended immediate as second operand |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Register second operand |
| imm_val | input | IMM_W | Immediate field |
| result | output | W | Registered result |
| ovf_req | output | 1 | Registered signed-overflow exception request |

## Verification
A 6-bit copy of the unit with a 3-bit immediate is driven through every operand pair under all eight codes. This covers every sign combination, every wrap of the sum and every case where the signed and unsigned orderings disagree, so a comparison that ignores overflow or takes the wrong sign convention cannot hide. A second sweep pairs every first operand with every immediate under every code. Its negative immediates separate sign extension from zero extension, and its unsigned-add cases confirm that sign extension still applies there. A 32-bit copy then takes directed corner vectors: the largest and smallest values, zero minus the most negative value, subtraction of zero, and mixed-sign comparisons whose difference overflows.

// File: rtl/int_addsub_pkg.sv
package int_addsub_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_ADDU = 3'b010,
    OP_SUBU = 3'b011,
    OP_SLT  = 3'b100,
    OP_SLTU = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } arith_op_e;
endpackage

// File: rtl/opnd_prep.sv
module opnd_prep #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [W-1:0]     reg_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  output logic [W-1:0]     b_out
);
  localparam int EXT_W = W - IMM_W;
  logic [W-1:0] imm_wide;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_wide = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_wide = imm[W-1:0];
    end
  endgenerate

  assign b_out = use_imm ? imm_wide : reg_b;

  always_comb begin
    if (use_imm && EXT_W > 0)
      AST_IMM_SIGN: assert (b_out[W-1] == imm[IMM_W-1]); // R7
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W-1:0] b_inv;
  logic [W:0]   full;

  assign b_inv = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_inv} + {{W{1'b0}}, sub};
  assign sum   = full[W-1:0];
  assign carry = full[W];
  assign ovf   = (a[W-1] == b_inv[W-1]) && (sum[W-1] != a[W-1]);
  assign lt_s  = sum[W-1] ^ ovf;
  assign lt_u  = ~carry;

  always_comb begin
    if (sub && b == '0)
      AST_SUB_ZERO_SAFE: assert (!ovf && sum == a); // R3
  end
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  int_addsub_pkg::arith_op_e     op,
  input  logic [W-1:0]                  sum,
  input  logic                          ovf,
  input  logic                          lt_s,
  input  logic                          lt_u,
  output logic [W-1:0]                  result,
  output logic                          ovf_req
);
  import int_addsub_pkg::*;
  logic [W-1:0] res_d;
  logic         ovf_d;

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_d = sum;
        ovf_d = ovf;
      end
      OP_ADDU, OP_SUBU: res_d = sum;
      OP_SLT:  res_d = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: res_d = {{(W-1){1'b0}}, lt_u};
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      ovf_req <= 1'b0;
    end else begin
      result  <= res_d;
      ovf_req <= ovf_d;
    end
  end
endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_code,
  input  logic             imm_sel,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic [IMM_W-1:0] imm_val,
  output logic [W-1:0]     result,
  output logic             ovf_req
);
  import int_addsub_pkg::*;

  arith_op_e    op;
  logic         sub;
  logic [W-1:0] b2;
  logic [W-1:0] sum;
  logic         carry, ovf, lt_s, lt_u;

  assign op  = arith_op_e'(op_code);
  assign sub = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);

  opnd_prep #(.W(W), .IMM_W(IMM_W)) u_prep (
    .reg_b(opnd_b), .imm(imm_val), .use_imm(imm_sel), .b_out(b2)
  );

  addsub_core #(.W(W)) u_core (
    .a(opnd_a), .b(b2), .sub(sub), .sum(sum), .carry(carry),
    .ovf(ovf), .lt_s(lt_s), .lt_u(lt_u)
  );

  result_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .op(op), .sum(sum), .ovf(ovf),
    .lt_s(lt_s), .lt_u(lt_u), .result(result), .ovf_req(ovf_req)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (result == '0 && !ovf_req)); // R1
  AST_ADD_MIXED_SIGN: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'b000 && !imm_sel && opnd_a[W-1] != opnd_b[W-1]) |=> !ovf_req); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'b010 || op_code == 3'b011) |=> !ovf_req); // R4
  AST_SLT_ONEBIT: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'b100) |=> (result[W-1:1] == '0 && !ovf_req)); // R5
  AST_SLTU_ONEBIT: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'b101) |=> (result[W-1:1] == '0 && !ovf_req)); // R6
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_code[2:1] == 2'b11) |=> (result == '0 && !ovf_req)); // R8
endmodule

// File: tb/int_addsub_unit_tb.sv
`timescale 1ns/1ps
module int_addsub_unit_tb;
  localparam int SW = 6, SI = 3, WW = 32, WI = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0] s_op = '0, w_op = '0;
  logic s_imm = 1'b0, w_imm = 1'b0;
  logic [SW-1:0] s_a = '0, s_b = '0, s_res;
  logic [SI-1:0] s_iv = '0;
  logic [WW-1:0] w_a = '0, w_b = '0, w_res;
  logic [WI-1:0] w_iv = '0;
  logic s_ovf, w_ovf;

  int total = 0, bad = 0;
  bit finished = 0;

  int_addsub_unit #(.W(SW), .IMM_W(SI)) u_dut (
    .clk(clk), .rst(rst), .op_code(s_op), .imm_sel(s_imm), .opnd_a(s_a),
    .opnd_b(s_b), .imm_val(s_iv), .result(s_res), .ovf_req(s_ovf));

  int_addsub_unit #(.W(WW), .IMM_W(WI)) u_wide (
    .clk(clk), .rst(rst), .op_code(w_op), .imm_sel(w_imm), .opnd_a(w_a),
    .opnd_b(w_b), .imm_val(w_iv), .result(w_res), .ovf_req(w_ovf));

  function automatic longint sx(int w, longint v);
    longint m = (longint'(1) << w) - 1;
    v = v & m;
    if (v[w-1]) return v - (longint'(1) << w);
    return v;
  endfunction

  // returns {ovf, result}
  function automatic logic [64:0] model(int w, int op, longint a, longint b);
    longint m = (longint'(1) << w) - 1;
    longint mx = (longint'(1) << (w-1)) - 1;
    longint mn = -(longint'(1) << (w-1));
    longint s;
    logic o = 1'b0;
    longint r = 0;
    a = a & m; b = b & m;
    case (op)
      0: begin s = sx(w,a) + sx(w,b); o = (s > mx) || (s < mn); r = s & m; end
      1: begin s = sx(w,a) - sx(w,b); o = (s > mx) || (s < mn); r = s & m; end
      2: r = (a + b) & m;
      3: r = (a - b) & m;
      4: r = (sx(w,a) < sx(w,b)) ? 1 : 0;
      5: r = (a < b) ? 1 : 0;
      default: r = 0;
    endcase
    return {o, r[63:0]};
  endfunction

  function automatic string tag(int op, bit immv);
    if (immv) return "R7";
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string rq, longint act_r, logic act_o, longint exp_r, logic exp_o);
    total++;
    if (act_r != exp_r || act_o !== exp_o) begin
      bad++;
      $display("FAIL %s actual res=%0h ovf=%0b expected res=%0h ovf=%0b",
               rq, act_r, act_o, exp_r, exp_o);
    end
  endtask

  task automatic run_small(int op, bit immv, int a, int b);
    logic [64:0] e;
    longint bv;
    s_op = op[2:0]; s_imm = immv; s_a = a[SW-1:0];
    s_b = immv ? '0 : b[SW-1:0];
    s_iv = immv ? b[SI-1:0] : '0;
    bv = immv ? sx(SI, b) : b;
    @(posedge clk); #1;
    e = model(SW, op, a, bv);
    check(tag(op, immv), longint'(s_res), s_ovf, e[63:0], e[64]);
  endtask

  task automatic run_wide(string rq, int op, longint a, longint b);
    logic [64:0] e;
    w_op = op[2:0]; w_imm = 1'b0; w_a = a[WW-1:0]; w_b = b[WW-1:0];
    @(posedge clk); #1;
    e = model(WW, op, a, b);
    check(rq, longint'(w_res), w_ovf, e[63:0], e[64]);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [64:0] e;
    s_op = 3'd0; s_a = 6'd5; s_b = 6'd7;
    w_op = 3'd0; w_a = 32'd9; w_b = 32'd9;
    repeat (3) @(posedge clk);
    #1;
    check("R1", longint'(s_res), s_ovf, 0, 1'b0);
    check("R1", longint'(w_res), w_ovf, 0, 1'b0);
    rst = 1'b0;

    // R9: registered output holds until the next edge
    run_small(0, 0, 10, 3);
    s_op = 3'd1; s_a = 6'd1; s_b = 6'd2;
    #2;
    check("R9", longint'(s_res), s_ovf, 13, 1'b0);
    @(posedge clk); #1;
    e = model(SW, 1, 1, 2);
    check("R9", longint'(s_res), s_ovf, e[63:0], e[64]);

    for (int op = 0; op < 8; op++)
      for (int a = 0; a < (1 << SW); a++)
        for (int b = 0; b < (1 << SW); b++)
          run_small(op, 0, a, b);

    for (int op = 0; op < 8; op++)
      for (int a = 0; a < (1 << SW); a++)
        for (int i = 0; i < (1 << SI); i++)
          run_small(op, 1, a, i);

    // wide corner vectors
    run_wide("R2", 0, 64'h7FFF_FFFF, 1);
    run_wide("R2", 0, 64'h8000_0000, 64'h8000_0000);
    run_wide("R2", 0, 64'h7FFF_FFFF, 64'h8000_0000);
    run_wide("R3", 1, 0, 64'h8000_0000);
    run_wide("R3", 1, 64'h8000_0000, 0);
    run_wide("R3", 1, 64'h8000_0000, 1);
    run_wide("R4", 2, 64'hFFFF_FFFF, 1);
    run_wide("R4", 3, 0, 64'h8000_0000);
    run_wide("R5", 4, 64'h8000_0000, 64'h7FFF_FFFF);
    run_wide("R5", 4, 64'h7FFF_FFFF, 64'h8000_0000);
    run_wide("R5", 4, 64'hFFFF_FFFF, 0);
    run_wide("R6", 5, 64'hFFFF_FFFF, 0);
    run_wide("R6", 5, 1, 64'h8000_0000);
    run_wide("R8", 6, 64'h1234_5678, 5);
    run_wide("R8", 7, 64'h8000_0000, 64'h8000_0000);

    // wide immediate: negative immediate under unsigned add
    w_op = 3'd2; w_imm = 1'b1; w_a = 32'd1; w_iv = 16'hFFFE;
    @(posedge clk); #1;
    check("R7", longint'(w_res), w_ovf, 64'hFFFF_FFFF, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule